// File: doc/BRIEF.md
# Port-Width Transfer Splitter with Byte-Lane Steering

This block sits between an internal requester and an external device port. It takes one read or write of a byte, a halfword, a word or a four-word line. It breaks that access into the beats that the selected device's port width allows, which is either a full 32-bit port or an 8-bit port. For every beat it places write data on the right byte lanes of the 32-bit external data path and drives the matching byte enables. On reads it picks the incoming bytes off those lanes and packs them into one result.

Configuration arrives with each request and is latched when the request is accepted:
- the port width;
- for an 8-bit port, whether the data rides on the top or the bottom byte lane;
- separate read and write burst enables, which decide whether a multi-beat access is marked as one burst or as a string of single transfers;
- whether byte enables are driven on reads as well as on writes.

Each beat is held until the external side acknowledges it. A done pulse follows the acknowledge of the last beat. Beat timing, such as setup, wait states and hold, belongs to a neighbouring block.

Top module: `xfer_split`

## Requirements
- R1: After reset, `beat_req`, `beat_burst`, `done`, `bus_be`, `bus_wdata` and `rd_data` are all zero.
- R2: `start` is accepted only while no transfer is in progress. A `start` pulse during a transfer changes neither that transfer's beats nor its single `done` pulse, and it does not launch a second transfer.
- R3: Beat count, with `req_size` encoded 0 = byte, 1 = halfword, 2 = word, 3 = line (four words):
  - on a 32-bit port (`cfg_port8` = 0) every non-line access takes 1 beat and a line takes 4 beats;
  - on an 8-bit port an access takes one beat per byte (1, 2, 4 or 16 beats).
- R4: Byte lanes are numbered by address offset: offset k within a word maps to data bits [31-8k:24-8k] and to `bus_be` bit 3-k. On a 32-bit port, each byte of the access goes on the lane of its own address offset, and only the lanes it covers are enabled.
- R5: On an 8-bit port every beat uses exactly one lane. With `cfg_lane_shift` = 0 that lane is bits [31:24] (`bus_be` = 4'b1000). With `cfg_lane_shift` = 1 it is bits [7:0] (`bus_be` = 4'b0001).
- R6: Beats are issued in ascending address order. `beat_addr` is the byte offset, within the line, of the first byte a beat carries. A halfword ignores `req_addr[0]`, and a word or a line starts at offset 0.
- R7: `beat_burst` is high on every beat of an access that needs more than one beat, but only if the burst enable for that direction (`cfg_burst_wr` for writes, `cfg_burst_rd` for reads) is set. Otherwise every beat is a single transfer.
- R8: An access that fits in one beat, including a word on a 32-bit port, is never marked as a burst, whatever the burst enables say.
- R9: Byte enables are driven on write beats always. On read beats they are driven only when `cfg_be_both` = 1, and are 0 otherwise.
- R10: Data streams are big-endian: byte j of an access sits at bits [127-8j:120-8j] of `req_wdata` and of `rd_data`. Bytes of `rd_data` that a read does not cover are 0, and `rd_data` holds its value until the next accepted `start`.
- R11: While `beat_req` is high and `beat_ack` is low, `beat_addr`, `bus_wdata` and `bus_be` stay unchanged.
- R12: `done` is high for exactly one cycle, the cycle after the acknowledge of the final beat, and `beat_req` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 line |
| req_addr | input | 2 | Low address bits of the access |
| req_wdata | input | 128 | Write stream, first byte in the top bits |
| cfg_port8 | input | 1 | 1 = 8-bit port, 0 = 32-bit port |
| cfg_lane_shift | input | 1 | 8-bit port on bits [7:0] when 1, on [31:24] when 0 |
| cfg_burst_rd | input | 1 | Burst enable for reads |
| cfg_burst_wr | input | 1 | Burst enable for writes |
| cfg_be_both | input | 1 | Drive byte enables on reads too |
| beat_ack | input | 1 | Acknowledge of the current beat |
| bus_rdata | input | 32 | Read data lanes |
| beat_req | output | 1 | A beat is presented |
| beat_write | output | 1 | Direction of the presented beat |
| beat_addr | output | 4 | Byte offset of the beat within the line |
| beat_burst | output | 1 | Beat belongs to a burst |
| bus_wdata | output | 32 | Write data lanes |
| bus_be | output | 4 | Byte enables, bit 3 = bits [31:24] |
| rd_data | output | 128 | Assembled read stream |
| done | output | 1 | One-cycle end of transfer pulse |

## Verification
A wrong beat index or beat count shows up on the very next acknowledged beat, as a wrong `beat_addr` or lane data, or as `done` arriving early or late by at least one beat. Latched configuration that is lost or overwritten by a `start` during a busy period shows up at once on `bus_be` or `beat_burst` of the following beat. A wrong lane or position in the read collector only shows up in `rd_data` at `done`, so every read scenario compares the whole assembled stream there, including the bytes that must stay zero.

// File: rtl/xfer_split_pkg.sv
`timescale 1ns/1ps
package xfer_split_pkg;

    // Byte lanes of the external data path.
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LINE = 2'd3
    } xfer_size_e;

    // Settings latched when a request is accepted.
    typedef struct packed {
        logic       write;
        xfer_size_e size;
        logic [1:0] off;
        logic       port8;
        logic       shift;
        logic       burst;
        logic       be_both;
    } xfer_cfg_t;

endpackage

// File: rtl/split_plan.sv
`timescale 1ns/1ps
// Works out how many beats an access needs, where it starts, and whether it is a burst.
module split_plan
    import xfer_split_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    localparam int LINE_BYTES = LINE_WORDS * LANES,
    localparam int CNT_W = $clog2(LINE_BYTES + 1)
) (
    input  xfer_size_e       size,
    input  logic [1:0]       addr,
    input  logic             port8,
    input  logic             write,
    input  logic             burst_rd,
    input  logic             burst_wr,
    output logic [CNT_W-1:0] nbeats,
    output logic [1:0]       off,
    output logic             burst
);

    logic [CNT_W-1:0] nbytes;

    always_comb begin
        case (size)
            SZ_BYTE: begin nbytes = CNT_W'(1);          off = addr;            end
            SZ_HALF: begin nbytes = CNT_W'(2);          off = {addr[1], 1'b0}; end
            SZ_WORD: begin nbytes = CNT_W'(LANES);      off = 2'd0;            end
            default: begin nbytes = CNT_W'(LINE_BYTES); off = 2'd0;            end
        endcase
        if (port8) begin
            nbeats = nbytes;
        end else if (size == SZ_LINE) begin
            nbeats = CNT_W'(LINE_WORDS);
        end else begin
            nbeats = CNT_W'(1);
        end
        burst = (nbeats > CNT_W'(1)) && (write ? burst_wr : burst_rd);
    end

endmodule

// File: rtl/split_lanes.sv
`timescale 1ns/1ps
// Steers the current beat onto byte lanes: write data, enables, offset, read positions.
module split_lanes
    import xfer_split_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    localparam int LINE_BYTES = LINE_WORDS * LANES,
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int IDX_W = $clog2(LINE_BYTES)
) (
    input  logic                   port8,
    input  logic                   shift,
    input  xfer_size_e             size,
    input  logic [1:0]             off,
    input  logic                   write,
    input  logic                   be_both,
    input  logic [IDX_W-1:0]       beat_idx,
    input  logic [LINE_BITS-1:0]   wdata,
    output logic [LANES*8-1:0]     bus_wdata,
    output logic [LANES-1:0]       bus_be,
    output logic [IDX_W-1:0]       beat_addr,
    output logic [LANES-1:0]       lane_act,
    output logic [LANES*IDX_W-1:0] lane_pos
);

    localparam int NARROW_LO = 0;
    localparam int NARROW_HI = LANES - 1;

    int span;

    always_comb begin
        case (size)
            SZ_BYTE: span = 1;
            SZ_HALF: span = 2;
            default: span = LANES;
        endcase
        if (port8) begin
            beat_addr = IDX_W'(off) + beat_idx;
        end else if (size == SZ_LINE) begin
            beat_addr = IDX_W'(int'(beat_idx) * LANES);
        end else begin
            beat_addr = IDX_W'(off);
        end
    end

    // Lane L carries address offset L of a word: bits [31-8L -: 8].
    for (genvar L = 0; L < LANES; L++) begin : g_lane
        logic             act;
        logic [IDX_W-1:0] pos;
        logic [7:0]       wbyte;

        always_comb begin
            act = 1'b0;
            pos = '0;
            if (port8) begin
                act = (L == (shift ? NARROW_HI : NARROW_LO));
                pos = beat_idx;
            end else if (size == SZ_LINE) begin
                act = 1'b1;
                pos = IDX_W'(int'(beat_idx) * LANES + L);
            end else if (L >= int'(off) && L < int'(off) + span) begin
                act = 1'b1;
                pos = IDX_W'(L - int'(off));
            end
            wbyte = wdata[LINE_BITS - 8 - 8 * int'(pos) +: 8];
        end

        assign lane_act[L]                   = act;
        assign lane_pos[L*IDX_W +: IDX_W]    = pos;
        assign bus_be[LANES-1-L]             = act && (write || be_both);
        assign bus_wdata[(LANES-1-L)*8 +: 8] = (act && write) ? wbyte : 8'h00;
    end

endmodule

// File: rtl/split_collect.sv
`timescale 1ns/1ps
// Packs read bytes from the active lanes into the big-endian result stream.
module split_collect
    import xfer_split_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    localparam int LINE_BYTES = LINE_WORDS * LANES,
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int IDX_W = $clog2(LINE_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   capture,
    input  logic [LANES-1:0]       lane_act,
    input  logic [LANES*IDX_W-1:0] lane_pos,
    input  logic [LANES*8-1:0]     bus_rdata,
    output logic [LINE_BITS-1:0]   rd_data
);

    logic [LINE_BITS-1:0] bytes_d, bytes_q;
    logic [IDX_W-1:0]     p;

    always_comb begin
        bytes_d = bytes_q;
        p = '0;
        if (clear) begin
            bytes_d = '0;
        end else if (capture) begin
            for (int L = 0; L < LANES; L++) begin
                if (lane_act[L]) begin
                    p = lane_pos[L*IDX_W +: IDX_W];
                    bytes_d[LINE_BITS - 8 - 8 * int'(p) +: 8] = bus_rdata[(LANES-1-L)*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_q <= '0;
        end else begin
            bytes_q <= bytes_d;
        end
    end

    assign rd_data = bytes_q;

    // R10: the result only moves on a new request or a read beat acknowledge
    assert_rd_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear) && !$past(capture) |-> $stable(bytes_q));

endmodule

// File: rtl/xfer_split.sv
`timescale 1ns/1ps
// Splits an internal access into port-width beats with lane steering.
module xfer_split
    import xfer_split_pkg::*;
#(
    parameter int LINE_WORDS = 4,
    localparam int LINE_BYTES = LINE_WORDS * LANES,
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int IDX_W = $clog2(LINE_BYTES),
    localparam int CNT_W = $clog2(LINE_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [1:0]           req_addr,
    input  logic [LINE_BITS-1:0] req_wdata,
    input  logic                 cfg_port8,
    input  logic                 cfg_lane_shift,
    input  logic                 cfg_burst_rd,
    input  logic                 cfg_burst_wr,
    input  logic                 cfg_be_both,
    input  logic                 beat_ack,
    input  logic [LANES*8-1:0]   bus_rdata,
    output logic                 beat_req,
    output logic                 beat_write,
    output logic [IDX_W-1:0]     beat_addr,
    output logic                 beat_burst,
    output logic [LANES*8-1:0]   bus_wdata,
    output logic [LANES-1:0]     bus_be,
    output logic [LINE_BITS-1:0] rd_data,
    output logic                 done
);

    typedef struct packed {
        logic                 busy;
        logic                 done;
        logic [IDX_W-1:0]     idx;
        logic [CNT_W-1:0]     nbeats;
        xfer_cfg_t            cfg;
        logic [LINE_BITS-1:0] wdata;
    } seq_t;

    seq_t st_d, st_q;

    logic [CNT_W-1:0]     plan_nbeats;
    logic [1:0]           plan_off;
    logic                 plan_burst;
    logic                 accept;
    logic                 last_beat;
    logic [LANES*8-1:0]   raw_wdata;
    logic [LANES-1:0]     raw_be;
    logic [LANES-1:0]     lane_act;
    logic [LANES*IDX_W-1:0] lane_pos;

    split_plan #(.LINE_WORDS(LINE_WORDS)) u_plan (
        .size     (xfer_size_e'(req_size)),
        .addr     (req_addr),
        .port8    (cfg_port8),
        .write    (req_write),
        .burst_rd (cfg_burst_rd),
        .burst_wr (cfg_burst_wr),
        .nbeats   (plan_nbeats),
        .off      (plan_off),
        .burst    (plan_burst)
    );

    split_lanes #(.LINE_WORDS(LINE_WORDS)) u_lanes (
        .port8     (st_q.cfg.port8),
        .shift     (st_q.cfg.shift),
        .size      (st_q.cfg.size),
        .off       (st_q.cfg.off),
        .write     (st_q.cfg.write),
        .be_both   (st_q.cfg.be_both),
        .beat_idx  (st_q.idx),
        .wdata     (st_q.wdata),
        .bus_wdata (raw_wdata),
        .bus_be    (raw_be),
        .beat_addr (beat_addr),
        .lane_act  (lane_act),
        .lane_pos  (lane_pos)
    );

    split_collect #(.LINE_WORDS(LINE_WORDS)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .capture   (st_q.busy && beat_ack && !st_q.cfg.write),
        .lane_act  (lane_act),
        .lane_pos  (lane_pos),
        .bus_rdata (bus_rdata),
        .rd_data   (rd_data)
    );

    assign accept    = start && !st_q.busy;
    assign last_beat = (CNT_W'(st_q.idx) + CNT_W'(1)) == st_q.nbeats;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.busy        = 1'b1;
            st_d.idx         = '0;
            st_d.nbeats      = plan_nbeats;
            st_d.cfg.write   = req_write;
            st_d.cfg.size    = xfer_size_e'(req_size);
            st_d.cfg.off     = plan_off;
            st_d.cfg.port8   = cfg_port8;
            st_d.cfg.shift   = cfg_lane_shift;
            st_d.cfg.burst   = plan_burst;
            st_d.cfg.be_both = cfg_be_both;
            st_d.wdata       = req_wdata;
        end else if (st_q.busy && beat_ack) begin
            if (last_beat) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_req   = st_q.busy;
    assign beat_write = st_q.cfg.write;
    assign beat_burst = st_q.busy && st_q.cfg.burst;
    assign bus_wdata  = st_q.busy ? raw_wdata : '0;
    assign bus_be     = st_q.busy ? raw_be : '0;
    assign done       = st_q.done;

    // R11: a beat waiting for its acknowledge does not move
    assert_beat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        beat_req && !beat_ack |=> beat_req && $stable(beat_addr)
                                  && $stable(bus_wdata) && $stable(bus_be));

    // R12: done follows an acknowledged beat and the port is idle then
    assert_done_after_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(beat_req && beat_ack) && !beat_req);

    // R12: done lasts one cycle
    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the burst marking does not change within one transfer
    assert_burst_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_req && $past(beat_req) |-> $stable(beat_burst));

    // R5: a narrow port enables at most one lane per beat
    assert_narrow_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        beat_req && st_q.cfg.port8 |-> $countones(bus_be) <= 1);

    // R9: read beats keep enables low unless enabled for both directions
    assert_read_be_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_req && !beat_write && !st_q.cfg.be_both |-> bus_be == '0);

endmodule

// File: tb/test_xfer_split.sv
`timescale 1ns/1ps
module test_xfer_split;

    localparam int LB = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd0;
    logic [1:0]    req_addr = 2'd0;
    logic [LB-1:0] req_wdata = '0;
    logic          cfg_port8 = 1'b0;
    logic          cfg_lane_shift = 1'b0;
    logic          cfg_burst_rd = 1'b0;
    logic          cfg_burst_wr = 1'b0;
    logic          cfg_be_both = 1'b0;
    logic          beat_ack = 1'b0;
    logic [31:0]   bus_rdata = '0;
    logic          beat_req, beat_write, beat_burst, done;
    logic [3:0]    beat_addr;
    logic [31:0]   bus_wdata;
    logic [3:0]    bus_be;
    logic [LB-1:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam logic [LB-1:0] PAT = 128'h00112233_44556677_8899AABB_CCDDEEFF;

    xfer_split i_xfer_split (
        .clk(clk), .rst_n(rst_n), .start(start), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_port8(cfg_port8), .cfg_lane_shift(cfg_lane_shift),
        .cfg_burst_rd(cfg_burst_rd), .cfg_burst_wr(cfg_burst_wr),
        .cfg_be_both(cfg_be_both), .beat_ack(beat_ack), .bus_rdata(bus_rdata),
        .beat_req(beat_req), .beat_write(beat_write), .beat_addr(beat_addr),
        .beat_burst(beat_burst), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .rd_data(rd_data), .done(done)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [LB-1:0] act,
                         input logic [LB-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected beats, built per byte from the requirement text
    int          ex_n;
    logic [3:0]  ex_addr [16];
    logic [3:0]  ex_be   [16];
    logic [31:0] ex_wd   [16];
    bit          ex_seen [16];
    logic [LB-1:0] ex_rd;
    bit          ex_burst;

    logic [3:0]  got_addr  [16];
    logic [3:0]  got_be    [16];
    logic [31:0] got_wd    [16];
    bit          got_burst [16];
    bit          got_wr    [16];

    function automatic logic [31:0] rpat(input int b);
        logic [31:0] v;
        for (int L = 0; L < 4; L++) v[31-8*L -: 8] = 8'(8'h40 + 4 * b + L);
        return v;
    endfunction

    task automatic model(input int size, input int addr, input bit p8, input bit sh,
                         input bit wr, input bit bw, input bit br, input bit bb);
        int nbytes, st, o, lane, b;
        nbytes = (size == 0) ? 1 : (size == 1) ? 2 : (size == 2) ? 4 : 16;
        st = (size == 0) ? addr : (size == 1) ? (addr & 2) : 0;
        ex_n = 0;
        ex_rd = '0;
        for (int i = 0; i < 16; i++) begin
            ex_be[i] = '0; ex_wd[i] = '0; ex_addr[i] = '0; ex_seen[i] = 0;
        end
        for (int j = 0; j < nbytes; j++) begin
            o = st + j;
            lane = p8 ? (sh ? 3 : 0) : (o % 4);
            b = p8 ? j : (o / 4);
            if (!ex_seen[b]) begin ex_addr[b] = 4'(o); ex_seen[b] = 1; end
            if (wr || bb) ex_be[b][3-lane] = 1'b1;
            if (wr) ex_wd[b][31-8*lane -: 8] = req_wdata[LB-1-8*j -: 8];
            ex_rd[LB-1-8*j -: 8] = 8'(8'h40 + 4 * b + lane);
            if (b + 1 > ex_n) ex_n = b + 1;
        end
        ex_burst = (ex_n > 1) && (wr ? bw : br);
    endtask

    // one transfer: drive, answer beats, compare against the model
    task automatic run(input int size, input int addr, input bit p8, input bit sh,
                       input bit wr, input bit bw, input bit br, input bit bb,
                       input int stall, input bit glitch, input string ltag,
                       input string btag);
        int n, w, cyc;
        logic [3:0]  f_addr, f_be;
        logic [31:0] f_wd;
        @(negedge clk);
        req_size = 2'(size); req_addr = 2'(addr); cfg_port8 = p8; cfg_lane_shift = sh;
        req_write = wr; cfg_burst_wr = bw; cfg_burst_rd = br; cfg_be_both = bb;
        model(size, addr, p8, sh, wr, bw, br, bb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0; w = 0; cyc = 0;
        f_addr = '0; f_be = '0; f_wd = '0;
        while (!done && cyc < 400) begin
            start = 1'b0;
            if (beat_req) begin
                if (w == 0) begin
                    f_addr = beat_addr; f_be = bus_be; f_wd = bus_wdata;
                    if (glitch && n == 1) begin
                        start = 1'b1; req_size = 2'd0; req_addr = 2'd3;
                        req_write = !wr; cfg_lane_shift = !sh; cfg_be_both = 1'b0;
                    end
                end
                if (w < stall) begin
                    beat_ack = 1'b0;
                    w++;
                end else begin
                    if (stall > 0)
                        check(beat_addr == f_addr && bus_be == f_be && bus_wdata == f_wd,
                              "R11 held beat", {beat_addr, bus_be, bus_wdata},
                              {f_addr, f_be, f_wd});
                    if (n < 16) begin
                        got_addr[n] = beat_addr; got_be[n] = bus_be; got_wd[n] = bus_wdata;
                        got_burst[n] = beat_burst; got_wr[n] = beat_write;
                    end
                    beat_ack = 1'b1;
                    bus_rdata = rpat(n);
                    n++;
                    w = 0;
                end
            end else begin
                beat_ack = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        beat_ack = 1'b0;
        start = 1'b0;
        check(done == 1'b1, "R12 done seen", LB'(done), LB'(1));
        check(n == ex_n, "R3 beat count", LB'(n), LB'(ex_n));
        for (int b = 0; b < ex_n && b < n; b++) begin
            check(got_addr[b] == ex_addr[b], "R6 beat address", LB'(got_addr[b]), LB'(ex_addr[b]));
            check(got_be[b] == ex_be[b], {ltag, " byte enables"}, LB'(got_be[b]), LB'(ex_be[b]));
            check(got_wd[b] == ex_wd[b], {ltag, " lane data"}, LB'(got_wd[b]), LB'(ex_wd[b]));
            check(got_burst[b] == ex_burst, {btag, " burst flag"}, LB'(got_burst[b]), LB'(ex_burst));
            check(got_wr[b] == wr, "R2 beat direction", LB'(got_wr[b]), LB'(wr));
        end
        if (!wr) check(rd_data == ex_rd, "R10 read stream", rd_data, ex_rd);
        @(negedge clk);
        check(done == 1'b0 && beat_req == 1'b0, "R12 done one cycle", LB'({done, beat_req}), LB'(0));
        if (glitch) begin
            for (int k = 0; k < 3; k++) begin
                check(beat_req == 1'b0 && done == 1'b0, "R2 no second transfer",
                      LB'({beat_req, done}), LB'(0));
                @(negedge clk);
            end
        end
        if (!wr) check(rd_data == ex_rd, "R10 read stream held", rd_data, ex_rd);
    endtask

    task automatic t_reset();
        check(beat_req == 0 && beat_burst == 0 && done == 0 && bus_be == 0
              && bus_wdata == 0 && rd_data == 0, "R1 reset state",
              {beat_req, beat_burst, done, bus_be, bus_wdata}, '0);
    endtask

    task automatic t_wide_bytes();
        req_wdata = PAT;
        for (int k = 0; k < 4; k++) run(0, k, 0, 0, 1, 1, 1, 0, 0, 0, "R4", "R8");
        run(0, 2, 0, 0, 0, 1, 1, 1, 0, 0, "R4", "R8");
    endtask

    task automatic t_wide_half_word();
        req_wdata = PAT;
        run(1, 3, 0, 0, 1, 1, 1, 0, 1, 0, "R4", "R8");
        run(1, 1, 0, 0, 0, 1, 1, 0, 0, 0, "R9", "R8");
        run(2, 1, 0, 0, 0, 1, 1, 1, 0, 0, "R4", "R8");
        run(2, 0, 0, 0, 1, 1, 1, 0, 0, 0, "R4", "R8");
    endtask

    task automatic t_narrow_word();
        req_wdata = ~PAT;
        run(2, 0, 1, 0, 1, 0, 1, 0, 0, 0, "R5", "R7");
        run(2, 2, 1, 0, 1, 1, 0, 0, 1, 0, "R5", "R7");
        run(2, 0, 1, 1, 0, 1, 1, 0, 0, 0, "R9", "R7");
        run(2, 0, 1, 1, 0, 1, 1, 1, 0, 0, "R9", "R7");
        run(0, 1, 1, 1, 1, 1, 1, 0, 0, 0, "R5", "R8");
    endtask

    task automatic t_line();
        req_wdata = PAT;
        run(3, 2, 0, 0, 1, 1, 1, 0, 2, 0, "R4", "R7");
        run(3, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R4", "R7");
        run(3, 0, 1, 1, 0, 0, 1, 0, 1, 0, "R9", "R7");
        run(3, 1, 1, 0, 1, 1, 0, 0, 0, 0, "R5", "R7");
    endtask

    task automatic t_dir_burst();
        req_wdata = PAT;
        run(1, 2, 1, 0, 0, 1, 0, 1, 0, 0, "R5", "R7");
        run(1, 2, 1, 0, 1, 1, 0, 0, 0, 0, "R5", "R7");
    endtask

    task automatic t_busy_start();
        req_wdata = ~PAT;
        run(2, 0, 1, 0, 1, 1, 1, 1, 1, 1, "R2", "R2");
        run(1, 0, 1, 1, 0, 1, 1, 1, 0, 1, "R2", "R2");
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wide_bytes();
        t_wide_half_word();
        t_narrow_word();
        t_line();
        t_dir_burst();
        t_busy_start();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule